// File: doc/BRIEF.md
# Two-Channel Buffered DMA Controller

This block is a two-channel DMA engine with one bus master port and a small register file. Software programs each channel with a source address, a destination address and a count. Each unit of data is moved by a read from the source into a one-word holding register, followed by a write of that word to the destination.

There are two ways to run a channel. In **peripheral mode** one channel feeds a fixed transmit address. It can be paced by a hardware request line, such as a serial port's transmit-empty flag, or it can free-run once software enables it. In **paired mode** the first channel reads and the second channel's destination address receives the data. This copies one memory region to another, and the request lines have no effect. Channel 1 always wins over channel 2, and a bus transaction that has started is never interrupted.

Top module: `dmac_two_chan`

## Requirements
- R1: The count register holds the number of units minus one. Programming N moves N+1 units, each unit is one read and one write, and the register steps down by one after every unit except the last.
- R2: Register select `cfg_sel[2]` picks the channel (0 = channel 1, 1 = channel 2). `cfg_sel[1:0]` picks the register: 0 = control, 1 = source, 2 = destination, 3 = count. Control bits are: bit0 enable, bit1 interrupt enable, bit2 hardware pacing, bit3 paired mode (channel 1 only, reads 0 on channel 2), bit4 done (read-only). Any write to a control register clears done.
- R3: When both channels become ready in the same idle cycle, channel 1's unit is issued first. Once `m_req` is high, it stays high with `m_addr` and `m_we` unchanged until `m_ack`.
- R4: Each unit reads the source address (`m_we`=0). The next transaction writes the returned word (`m_we`=1).
- R5: In peripheral mode the source address advances by `ADDR_STEP` per unit and the destination address stays fixed.
- R6: In paired mode, channel 1's source is read and channel 2's destination is written, and both advance per unit. Channel 1's count governs the transfer. Request lines are ignored, and channel 2 cannot run on its own while the paired bit is set.
- R7: After the last unit, the channel's enable bit clears, done sets and the count reads 0.
- R8: `irq[c]` is high exactly while channel c has done and interrupt enable both set.
- R9: With hardware pacing, each rising edge of the request seen while the channel is enabled moves exactly one unit. A request already high when the channel is enabled moves nothing, and a request held high moves nothing more.
- R10: Without hardware pacing, an enabled channel moves its units back to back until done.
- R11: After reset every register reads 0, `m_req` is low and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Channel and register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| hw_req | input | 2 | Hardware pacing requests, bit 0 for channel 1 |
| m_req | output | 1 | Bus transaction request |
| m_we | output | 1 | Bus write (1) or read (0) |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | DATA_W | Bus write data |
| m_rdata | input | DATA_W | Bus read data, valid with `m_ack` |
| m_ack | input | 1 | Bus transaction complete |
| irq | output | 2 | Per-channel completion interrupts |

## Verification
The bench targets the request edge rules. It holds a request high before and after enabling a channel, so a design that paces on level rather than edge would issue extra units. It raises both channels' requests in the same cycle; a wrong priority shows up as channel 2's read arriving first. Paired mode runs with channel 2 armed and its request toggling, so a design that lets channel 2 escape the pairing issues writes to channel 2's own addresses. Count-zero and interrupt-disabled runs expose off-by-one counts and interrupts that ignore their enable.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_t;

   localparam int CTRL_EN   = 0;
   localparam int CTRL_IE   = 1;
   localparam int CTRL_HW   = 2;
   localparam int CTRL_PAIR = 3;
   localparam int CTRL_DONE = 4;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_SRC  = 2'd1;
   localparam logic [1:0] REG_DST  = 2'd2;
   localparam logic [1:0] REG_CNT  = 2'd3;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int ADDR_STEP = 1,
   parameter bit LEAD      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        rd_reg,
   output logic [31:0]       rd_data,
   input  logic              hw_req,
   input  logic              pair_block,
   input  logic              take,
   input  logic              step_src,
   input  logic              step_dst,
   input  logic              step_cnt,
   output logic              ready,
   output logic              pair,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);
   localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

   logic             en, ie, hw, done, pend, hw_q;
   logic [CNT_W-1:0] cnt;
   logic             unused_bits;

   assign unused_bits = ^wr_data[31:CTRL_DONE];

   // Paired-mode bit exists only on the leading channel.
   generate
      if (LEAD) begin : g_pair
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pair <= 1'b0;
            else if (wr_en && wr_reg == REG_CTRL) pair <= wr_data[CTRL_PAIR];
         end
      end else begin : g_nopair
         assign pair = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ie   <= 1'b0;
         hw   <= 1'b0;
         done <= 1'b0;
         pend <= 1'b0;
         hw_q <= 1'b0;
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
      end else begin
         hw_q <= hw_req;
         if (!en || take) pend <= 1'b0;
         if (en && hw_req && !hw_q) pend <= 1'b1;
         if (step_src) src <= src + STEP;
         if (step_dst) dst <= dst + STEP;
         if (step_cnt) begin
            if (cnt == '0) begin
               en   <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - ONE;
            end
         end
         if (wr_en) begin
            case (wr_reg)
               REG_CTRL: begin
                  en   <= wr_data[CTRL_EN];
                  ie   <= wr_data[CTRL_IE];
                  hw   <= wr_data[CTRL_HW];
                  done <= 1'b0;
               end
               REG_SRC: src <= wr_data[ADDR_W-1:0];
               REG_DST: dst <= wr_data[ADDR_W-1:0];
               default: cnt <= wr_data[CNT_W-1:0];
            endcase
         end
      end
   end

   assign ready = en && !pair_block && (pair || !hw || pend);
   assign irq   = done && ie;

   always_comb begin
      case (rd_reg)
         REG_CTRL: rd_data = 32'({done, pair, hw, ie, en});
         REG_SRC:  rd_data = 32'(src);
         REG_DST:  rd_data = 32'(dst);
         default:  rd_data = 32'(cnt);
      endcase
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cnt && cnt != '0 && !wr_en) |=> (cnt == $past(cnt) - ONE)); // R1
   AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cnt && cnt == '0 && !wr_en) |=> (!en && done)); // R7
   AST_EDGE_PACE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> hw_q); // R9
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
   import dmac_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             ready,
   input  logic                   pair_mode,
   input  logic [1:0][ADDR_W-1:0] src_all,
   input  logic [1:0][ADDR_W-1:0] dst_all,
   output logic                   m_req,
   output logic                   m_we,
   output logic [ADDR_W-1:0]      m_addr,
   output logic [DATA_W-1:0]      m_wdata,
   input  logic [DATA_W-1:0]      m_rdata,
   input  logic                   m_ack,
   output logic [1:0]             take,
   output logic [1:0]             step_src,
   output logic [1:0]             step_dst,
   output logic [1:0]             step_cnt
);
   eng_state_t        state;
   logic              cur, pair_q, grant_idx;
   logic [DATA_W-1:0] hold;

   assign grant_idx = ready[0] ? 1'b0 : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ENG_IDLE;
         cur    <= 1'b0;
         pair_q <= 1'b0;
         hold   <= '0;
      end else begin
         case (state)
            ENG_IDLE: if (|ready) begin
               cur    <= grant_idx;
               pair_q <= pair_mode && !grant_idx;
               state  <= ENG_RD;
            end
            ENG_RD: if (m_ack) begin
               hold  <= m_rdata;
               state <= ENG_WR;
            end
            default: if (m_ack) state <= ENG_IDLE;
         endcase
      end
   end

   always_comb begin
      take     = '0;
      step_src = '0;
      step_dst = '0;
      step_cnt = '0;
      if (state == ENG_IDLE && |ready) take[grant_idx] = 1'b1;
      if (state == ENG_WR && m_ack) begin
         step_src[cur] = 1'b1;
         step_cnt[cur] = 1'b1;
         if (pair_q) step_dst[1] = 1'b1;
      end
      m_req   = (state != ENG_IDLE);
      m_we    = (state == ENG_WR);
      m_wdata = hold;
      if (state == ENG_WR) m_addr = pair_q ? dst_all[1] : dst_all[cur];
      else                 m_addr = src_all[cur];
   end

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we))); // R3
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_we && m_ack) |=> (m_req && m_we)); // R4
   AST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_req && ready == 2'b11) |=> (m_req && !m_we && !cur)); // R3
endmodule

// File: rtl/dmac_two_chan.sv
module dmac_two_chan
   import dmac_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int ADDR_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [1:0]        hw_req,
   output logic              m_req,
   output logic              m_we,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic              m_ack,
   output logic [1:0]        irq
);
   localparam int NCH = 2;

   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (DATA_W >= 8) else $error("DATA_W too small");
      assert (ADDR_STEP >= 1) else $error("ADDR_STEP must be positive");
   end

   logic [NCH-1:0]             ready, pair_v, take, step_src, step_dst, step_cnt;
   logic [NCH-1:0][ADDR_W-1:0] src_v, dst_v;
   logic [NCH-1:0][31:0]       rd_v;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dmac_chan #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_STEP(ADDR_STEP), .LEAD(i == 0)
         ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_we && (cfg_sel[2] == 1'(i))),
            .wr_reg     (cfg_sel[1:0]),
            .wr_data    (cfg_wdata),
            .rd_reg     (cfg_sel[1:0]),
            .rd_data    (rd_v[i]),
            .hw_req     (hw_req[i]),
            .pair_block ((i != 0) && pair_v[0]),
            .take       (take[i]),
            .step_src   (step_src[i]),
            .step_dst   (step_dst[i]),
            .step_cnt   (step_cnt[i]),
            .ready      (ready[i]),
            .pair       (pair_v[i]),
            .src        (src_v[i]),
            .dst        (dst_v[i]),
            .irq        (irq[i])
         );
      end
   endgenerate

   assign cfg_rdata = rd_v[cfg_sel[2]];

   dmac_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (ready),
      .pair_mode (|pair_v),
      .src_all   (src_v),
      .dst_all   (dst_v),
      .m_req     (m_req),
      .m_we      (m_we),
      .m_addr    (m_addr),
      .m_wdata   (m_wdata),
      .m_rdata   (m_rdata),
      .m_ack     (m_ack),
      .take      (take),
      .step_src  (step_src),
      .step_dst  (step_dst),
      .step_cnt  (step_cnt)
   );

   AST_PAIR_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_v[0] && m_req && !m_we && m_addr == src_v[1] && src_v[1] != src_v[0]) |-> !ready[1]); // R6
   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel[1:0] == REG_CTRL) |=> !irq[$past(cfg_sel[2])]); // R8
endmodule

// File: tb/dmac_two_chan_tb.sv
module dmac_two_chan_tb;
   typedef struct {
      logic        we;
      logic [15:0] addr;
      logic [31:0] data;
   } txn_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  hw_req = '0;
   logic        m_req, m_we, m_ack;
   logic [15:0] m_addr;
   logic [31:0] m_wdata, m_rdata;
   logic [1:0]  irq;

   int   checks = 0;
   int   errors = 0;
   int   n_txn  = 0;
   txn_t exp_q[$];

   always #4 clk = ~clk;

   dmac_two_chan u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_ack(m_ack), .irq(irq)
   );

   function automatic logic [31:0] mem_val(input logic [15:0] a);
      return {~a, a};
   endfunction

   assign m_rdata = mem_val(m_addr);
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_ack <= 1'b0;
      else        m_ack <= m_req && !m_ack;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: compare each completed bus transaction against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && m_req && m_ack) begin
         n_txn++;
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R4: actual unexpected txn we=%b addr=%h expected none", m_we, m_addr);
         end else begin
            txn_t e;
            e = exp_q.pop_front();
            chk("R4 we", 32'(m_we), 32'(e.we));
            chk("R5 addr", 32'(m_addr), 32'(e.addr));
            if (e.we) chk("R4 wdata", m_wdata, e.data);
         end
      end
   end

   task automatic push_unit(input logic [15:0] s, input logic [15:0] d);
      exp_q.push_back('{we: 1'b0, addr: s, data: mem_val(s)});
      exp_q.push_back('{we: 1'b1, addr: d, data: mem_val(s)});
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [31:0] data);
      @(negedge clk);
      cfg_sel = sel;
      #1 data = cfg_rdata;
   endtask

   task automatic wait_idle(input string req);
      bit ok = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (exp_q.size() == 0 && !m_req) begin ok = 1'b1; break; end
      end
      repeat (4) @(negedge clk);
      chk({req, " completion"}, 32'(ok), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      for (int s = 0; s < 8; s++) begin
         rd(3'(s), v);
         chk("R11 reg", v, 32'h0);
      end
      chk("R11 m_req", 32'(m_req), 0);
      chk("R11 irq", 32'(irq), 0);

      // R10/R5/R1: software run on channel 1, 4 units, fixed destination
      wr(3'd1, 32'h0100); wr(3'd2, 32'h0040); wr(3'd3, 32'd3);
      for (int i = 0; i < 4; i++) push_unit(16'h0100 + 16'(i), 16'h0040);
      base = n_txn;
      wr(3'd0, 32'h3);
      wait_idle("R10");
      chk("R1 units", 32'(n_txn - base), 32'd8);
      chk("R8 irq", 32'(irq), 32'b01);
      rd(3'd0, v); chk("R7 ctrl", v, 32'h12);
      rd(3'd3, v); chk("R7 count", v, 32'h0);
      rd(3'd1, v); chk("R5 src", v, 32'h0104);
      rd(3'd2, v); chk("R5 dst", v, 32'h0040);
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R2 done clear", v, 32'h0);
      chk("R8 irq clear", 32'(irq), 0);

      // R1/R8: channel 2, count 0, interrupt disabled
      wr(3'd5, 32'h0500); wr(3'd6, 32'h0080); wr(3'd7, 32'd0);
      push_unit(16'h0500, 16'h0080);
      base = n_txn;
      wr(3'd4, 32'h1);
      wait_idle("R1");
      chk("R1 single unit", 32'(n_txn - base), 32'd2);
      chk("R8 irq masked", 32'(irq), 0);
      rd(3'd4, v); chk("R7 ctrl2", v, 32'h10);
      wr(3'd4, 32'h0);

      // R9: hardware pacing on channel 2
      hw_req[1] = 1'b1;
      wr(3'd5, 32'h0600); wr(3'd6, 32'h0090); wr(3'd7, 32'd1);
      base = n_txn;
      wr(3'd4, 32'h7);
      repeat (20) @(negedge clk);
      chk("R9 level at enable", 32'(n_txn - base), 0);
      hw_req[1] = 1'b0;
      push_unit(16'h0600, 16'h0090);
      @(negedge clk); hw_req[1] = 1'b1;
      repeat (20) @(negedge clk);
      chk("R9 one unit", 32'(n_txn - base), 32'd2);
      rd(3'd4, v); chk("R9 still armed", v, 32'h7);
      hw_req[1] = 1'b0;
      push_unit(16'h0601, 16'h0090);
      @(negedge clk); hw_req[1] = 1'b1;
      repeat (20) @(negedge clk);
      chk("R9 second unit", 32'(n_txn - base), 32'd4);
      rd(3'd4, v); chk("R7 hw done", v, 32'h16);
      chk("R8 irq ch2", 32'(irq), 32'b10);
      wr(3'd4, 32'h0);
      hw_req = '0;

      // R3: simultaneous requests, channel 1 first
      wr(3'd1, 32'h0700); wr(3'd2, 32'h00A0); wr(3'd3, 32'd0);
      wr(3'd5, 32'h0800); wr(3'd6, 32'h00B0); wr(3'd7, 32'd0);
      wr(3'd0, 32'h5); wr(3'd4, 32'h5);
      push_unit(16'h0700, 16'h00A0);
      push_unit(16'h0800, 16'h00B0);
      @(negedge clk); hw_req = 2'b11;
      wait_idle("R3");
      rd(3'd0, v); chk("R3 ch1 done", v, 32'h14);
      rd(3'd4, v); chk("R3 ch2 done", v, 32'h14);
      hw_req = '0;
      wr(3'd0, 32'h0); wr(3'd4, 32'h0);

      // R6: paired copy, requests toggling, channel 2 armed
      wr(3'd1, 32'h0200); wr(3'd3, 32'd2);
      wr(3'd5, 32'h0900); wr(3'd6, 32'h0300);
      wr(3'd4, 32'h5);
      for (int i = 0; i < 3; i++) push_unit(16'h0200 + 16'(i), 16'h0300 + 16'(i));
      base = n_txn;
      wr(3'd0, 32'hF);
      @(negedge clk); hw_req = 2'b11;
      repeat (3) @(negedge clk); hw_req = 2'b00;
      repeat (3) @(negedge clk); hw_req = 2'b11;
      wait_idle("R6");
      chk("R6 units", 32'(n_txn - base), 32'd6);
      rd(3'd1, v); chk("R6 src1", v, 32'h0203);
      rd(3'd6, v); chk("R6 dst2", v, 32'h0303);
      rd(3'd5, v); chk("R6 src2 untouched", v, 32'h0900);
      rd(3'd0, v); chk("R6 ctrl1", v, 32'h1E);
      rd(3'd4, v); chk("R6 ch2 not run", v, 32'h5);
      chk("R8 irq pair", 32'(irq), 32'b01);
      wr(3'd4, 32'h0); wr(3'd0, 32'h0);
      hw_req = '0;
      repeat (10) @(negedge clk);
      chk("R4 queue drained", 32'(exp_q.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule